// File: doc/BRIEF.md
# Camera Pixel Capture with Grayscale Conversion

This block sits on the pixel clock of a parallel image sensor. It takes the sensor's 8-bit data bus, the frame sync strobe and the line-valid strobe. Each pair of consecutive bytes is joined into one 16-bit RGB565 pixel. The block tracks the pixel's column and row in a 640x480 frame.

Each finished pixel becomes an 8-bit luminance value, computed with shifts and adds only. Pixels that fall inside a 150x150 window at the top-left corner of the frame are then written to a grayscale frame buffer. The write has three parts: an address, a data byte and a one-cycle write enable. The buffer is stored in row-major order.

Sensor configuration, clock generation and the buffer RAM are outside the block.

Top module: `cam_gray_capture`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `wr_en_o` is 0. `wr_addr_o` and `wr_data_o` are 0 at that time.
- R2: While `href_i` is high, bytes are paired in arrival order. The first byte of a pair is bits 15:8 of the pixel and the second byte is bits 7:0. The write for a pixel appears on the outputs in the cycle after the clock edge that samples its second byte, and it lasts exactly one cycle. Two writes are never back to back.
- R3: The pixel fields are red = bits 15:11, green = bits 10:5 and blue = bits 4:0. Each field is widened to 8 bits by repeating its top bits. The gray value is R/4 + R/32 + G/2 + G/16 + B/16 + B/32, using integer division. The result is saturated at 255. For example, 0xFFFF gives 234, 0x0000 gives 0 and 0xF800 gives 70.
- R4: A rising edge of `href_i` sets the column back to 0 and makes the byte sampled on that edge the first byte of a pair. A leftover odd byte from the previous line is discarded.
- R5: A rising edge of `vsync_i` sets the row back to 0. Each falling edge of `href_i` advances the row by one.
- R6: The write address is row*150 + column. A write happens only when row < 150 and column < 150. A full frame therefore produces exactly 22500 writes, at addresses 0 to 22499.
- R7: No write happens for a byte sampled while `href_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vsync_i | input | 1 | Frame sync; its rising edge starts a frame |
| href_i | input | 1 | Line valid; high while the bytes of a row arrive |
| data_i | input | 8 | Sensor byte |
| wr_en_o | output | 1 | Buffer write enable, one cycle per stored pixel |
| wr_addr_o | output | 15 | Buffer write address, row-major |
| wr_data_o | output | 8 | Gray value to store |

## Verification
Every write is due exactly one cycle after the clock edge that samples the second byte of its pair. The counter resets caused by the strobe edges also take effect on that same edge. The bench drives each byte on the falling clock edge and steps a behavioural model of the stream for the coming rising edge. On the next falling edge, it compares the enable, address and data with the model. This lines up the one-cycle output register on every cycle. Explicit checks cover the known colours, the window size, the discarding of an odd leftover byte and a restart of the frame in the middle.

// File: rtl/cgc_pkg.sv
package cgc_pkg;
    typedef struct packed {
        logic [4:0] red;
        logic [5:0] green;
        logic [4:0] blue;
    } rgb565_t;

    typedef struct packed {
        logic       phase;
        logic [7:0] hi;
    } pair_state_t;
endpackage

// File: rtl/cgc_byte_pair.sv
module cgc_byte_pair
    import cgc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        href_i,
    input  logic        href_rise_i,
    input  logic [7:0]  data_i,
    output logic        pix_valid_o,
    output rgb565_t     pix_o
);
    pair_state_t st_d, st_q;
    logic        phase_eff;

    always_comb begin
        st_d      = st_q;
        phase_eff = href_rise_i ? 1'b0 : st_q.phase;
        pix_valid_o = 1'b0;
        pix_o     = rgb565_t'({st_q.hi, data_i});
        if (href_i) begin
            if (!phase_eff) begin
                st_d.phase = 1'b1;
                st_d.hi    = data_i;
            end else begin
                st_d.phase  = 1'b0;
                pix_valid_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/cgc_luma.sv
module cgc_luma
    import cgc_pkg::*;
(
    input  rgb565_t    pix_i,
    output logic [7:0] gray_o
);
    logic [7:0] r8, g8, b8;
    logic [9:0] sum;

    always_comb begin
        r8  = {pix_i.red, pix_i.red[4:2]};
        g8  = {pix_i.green, pix_i.green[5:4]};
        b8  = {pix_i.blue, pix_i.blue[4:2]};
        sum = 10'(r8 >> 2) + 10'(r8 >> 5) + 10'(g8 >> 1) + 10'(g8 >> 4)
            + 10'(b8 >> 4) + 10'(b8 >> 5);
        gray_o = (sum > 10'd255) ? 8'hFF : sum[7:0];
    end
endmodule

// File: rtl/cgc_position.sv
module cgc_position #(
    parameter int FRAME_COLS = 640,
    parameter int FRAME_ROWS = 480,
    parameter int WIN_COLS   = 150,
    parameter int WIN_ROWS   = 150,
    localparam int COL_W  = $clog2(FRAME_COLS + 1),
    localparam int ROW_W  = $clog2(FRAME_ROWS + 1),
    localparam int ADDR_W = $clog2(WIN_COLS * WIN_ROWS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_i,
    input  logic              href_i,
    input  logic              pix_valid_i,
    output logic              href_rise_o,
    output logic [COL_W-1:0]  col_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [ADDR_W-1:0] row_base_o
);
    typedef struct packed {
        logic              vsync_prev;
        logic              href_prev;
        logic [COL_W-1:0]  col;
        logic [ROW_W-1:0]  row;
        logic [ADDR_W-1:0] base;
    } pos_state_t;

    pos_state_t st_d, st_q;
    logic vsync_rise, href_fall;

    always_comb begin
        st_d        = st_q;
        vsync_rise  = vsync_i && !st_q.vsync_prev;
        href_rise_o = href_i && !st_q.href_prev;
        href_fall   = !href_i && st_q.href_prev;
        st_d.vsync_prev = vsync_i;
        st_d.href_prev  = href_i;
        if (href_rise_o)
            st_d.col = '0;
        else if (pix_valid_i && st_q.col != COL_W'(FRAME_COLS))
            st_d.col = st_q.col + 1'b1;
        if (vsync_rise) begin
            st_d.row  = '0;
            st_d.base = '0;
        end else if (href_fall) begin
            if (st_q.row != ROW_W'(FRAME_ROWS)) st_d.row = st_q.row + 1'b1;
            if (st_q.row < ROW_W'(WIN_ROWS - 1))
                st_d.base = st_q.base + ADDR_W'(WIN_COLS);
        end
        col_o      = st_q.col;
        row_o      = st_q.row;
        row_base_o = st_q.base;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !href_i |=> $stable(col_o));
    // R5
    row_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vsync_i) |=> (row_o == '0));
endmodule

// File: rtl/cam_gray_capture.sv
module cam_gray_capture
    import cgc_pkg::*;
#(
    parameter int FRAME_COLS = 640,
    parameter int FRAME_ROWS = 480,
    parameter int WIN_COLS   = 150,
    parameter int WIN_ROWS   = 150,
    localparam int COL_W    = $clog2(FRAME_COLS + 1),
    localparam int ROW_W    = $clog2(FRAME_ROWS + 1),
    localparam int WIN_AREA = WIN_COLS * WIN_ROWS,
    localparam int ADDR_W   = $clog2(WIN_AREA)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              vsync_i,
    input  logic              href_i,
    input  logic [7:0]        data_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [7:0]        wr_data_o
);
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
    } wr_state_t;

    wr_state_t         wr_d, wr_q;
    logic              pix_valid, href_rise;
    rgb565_t           pix;
    logic [7:0]        gray;
    logic [COL_W-1:0]  col;
    logic [ROW_W-1:0]  row;
    logic [ADDR_W-1:0] row_base;

    cgc_byte_pair u_pair (
        .clk(clk), .rst_n(rst_n), .href_i(href_i), .href_rise_i(href_rise),
        .data_i(data_i), .pix_valid_o(pix_valid), .pix_o(pix)
    );

    cgc_position #(
        .FRAME_COLS(FRAME_COLS), .FRAME_ROWS(FRAME_ROWS),
        .WIN_COLS(WIN_COLS), .WIN_ROWS(WIN_ROWS)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .vsync_i(vsync_i), .href_i(href_i),
        .pix_valid_i(pix_valid), .href_rise_o(href_rise),
        .col_o(col), .row_o(row), .row_base_o(row_base)
    );

    cgc_luma u_luma (.pix_i(pix), .gray_o(gray));

    always_comb begin
        wr_d      = wr_q;
        wr_d.en   = pix_valid && (row < ROW_W'(WIN_ROWS)) && (col < COL_W'(WIN_COLS));
        if (wr_d.en) begin
            wr_d.addr = row_base + ADDR_W'(col);
            wr_d.data = gray;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= wr_d;
    end

    assign wr_en_o   = wr_q.en;
    assign wr_addr_o = wr_q.addr;
    assign wr_data_o = wr_q.data;

    // R6
    addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (wr_addr_o < ADDR_W'(WIN_AREA)));
    // R7
    idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !href_i |=> !wr_en_o);
    // R2
    no_back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |=> !wr_en_o);
endmodule

// File: tb/cam_gray_capture_bench.sv
`timescale 1ns/1ps
module cam_gray_capture_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vsync = 1'b0, href = 1'b0;
    logic [7:0]  data = 8'h00;
    logic        wr_en;
    logic [14:0] wr_addr;
    logic [7:0]  wr_data;

    always #2 clk = ~clk;

    cam_gray_capture u_cam_gray_capture (
        .clk(clk), .rst_n(rst_n), .vsync_i(vsync), .href_i(href), .data_i(data),
        .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    int checks = 0, failures = 0, cycles = 0;
    int m_row = 0, m_col = 0, m_phase = 0, m_hi = 0, m_pv = 0, m_ph = 0;
    bit exp_en = 0; int exp_addr = 0, exp_data = 0;
    int writes = 0, max_addr = -1, first_addr = -1;
    int seen[3] = '{-1, -1, -1};

    function automatic int ref_gray(int p);
        int r, g, b, r8, g8, b8, s;
        r = (p >> 11) & 31; g = (p >> 5) & 63; b = p & 31;
        r8 = r * 8 + r / 4; g8 = g * 4 + g / 16; b8 = b * 8 + b / 4;
        s = r8 / 4 + r8 / 32 + g8 / 2 + g8 / 16 + b8 / 16 + b8 / 32;
        return (s > 255) ? 255 : s;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One cycle: compare outputs from the last edge, drive, step model.
    task automatic step(bit v, bit h, int d);
        int prow;
        @(negedge clk);
        check("R2 R7 wr_en", int'(wr_en), int'(exp_en));
        if (wr_en && exp_en) begin
            check("R6 addr", int'(wr_addr), exp_addr);
            check("R3 gray", int'(wr_data), exp_data);
        end
        if (wr_en) begin
            writes++;
            if (int'(wr_addr) > max_addr) max_addr = int'(wr_addr);
            if (first_addr < 0) first_addr = int'(wr_addr);
            if (wr_addr < 3 && seen[wr_addr] < 0) seen[wr_addr] = int'(wr_data);
        end
        vsync = v; href = h; data = d[7:0];
        exp_en = 0;
        prow = m_row;
        if (h) begin
            if (!m_ph) begin m_col = 0; m_phase = 0; end
            if (m_phase == 0) begin m_hi = d & 255; m_phase = 1; end
            else begin
                m_phase = 0;
                if (prow < 150 && m_col < 150) begin
                    exp_en = 1; exp_addr = prow * 150 + m_col;
                    exp_data = ref_gray(m_hi * 256 + (d & 255));
                end
                if (m_col < 640) m_col++;
            end
        end
        if (v && !m_pv) m_row = 0;
        else if (!h && m_ph && m_row < 480) m_row++;
        m_pv = int'(v); m_ph = int'(h);
    endtask

    function automatic int pattern(int r, int c);
        if (r == 0 && c == 0) return 16'hFFFF;
        if (r == 0 && c == 1) return 16'h0000;
        if (r == 0 && c == 2) return 16'hF800;
        return ((r * 2731 + c * 977) ^ (c << 9)) & 16'hFFFF;
    endfunction

    task automatic frame_start();
        for (int i = 0; i < 3; i++) step(1, 0, 8'hA5);
        for (int i = 0; i < 3; i++) step(0, 0, 8'h5A);
    endtask

    task automatic line(int r, int npix);
        for (int c = 0; c < npix; c++) begin
            step(0, 1, pattern(r, c) >> 8);
            step(0, 1, pattern(r, c) & 255);
        end
        for (int i = 0; i < 4; i++) step(0, 0, 8'h3C + i);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) @(negedge clk);
        // R1
        check("R1 reset wr_en", int'(wr_en), 0);
        check("R1 reset addr", int'(wr_addr), 0);
        check("R1 reset data", int'(wr_data), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) step(0, 0, 8'hFF);
        // Full window frame with spill-over on both axes
        frame_start();
        writes = 0;
        for (int r = 0; r < 152; r++) line(r, 160);
        check("R6 writes per frame", writes, 22500);
        check("R6 last address", max_addr, 22499);
        check("R3 white", seen[0], 234);
        check("R3 black", seen[1], 0);
        check("R3 red", seen[2], 70);
        // R4: odd byte line then fresh line
        frame_start();
        writes = 0;
        for (int i = 0; i < 7; i++) step(0, 1, 8'h11 * (i + 1));
        for (int i = 0; i < 3; i++) step(0, 0, 8'h00);
        check("R4 odd line writes", writes, 3);
        writes = 0;
        line(1, 5);
        check("R4 fresh line writes", writes, 5);
        // R5: restart mid-frame
        line(2, 4);
        frame_start();
        first_addr = -1;
        line(0, 2);
        check("R5 restart first address", first_addr, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 8'h00);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule